// File: doc/BRIEF.md
# 1-Wire ROM Search Controller

This controller finds the 64-bit identifiers of all devices on a 1-Wire bus using the binary-tree search. It does not time the bus slots itself. A separate slot engine does that, and the controller drives it through a small request/acknowledge command port. The engine offers four operations: bus reset with presence sampling, sending one command byte, reading two slots, and writing one slot.

Each pulse on `next_req` runs one search pass and ends with a single-cycle response. The response carries the identifier and a status code. Between passes the controller keeps the working identifier, the deepest unresolved branch point and a completion flag. This lets repeated requests walk the whole device tree. A mode input chooses, for each request, between searching all devices and searching only devices in an alarm state.

Top module: `rom_search_ctrl`

## Requirements
- R1: A pass with `alarm_mode` low at the request sends command byte 0xF0. A pass with `alarm_mode` high sends 0xEC. The mode is sampled in the cycle `next_req` is accepted.
- R2: Engine op codes on `eng_op` are 0 = bus reset, 1 = send byte (`eng_byte`), 2 = read two slots, and 3 = write one slot (`eng_wbit`). A pass issues a reset, then a send, then 64 pairs of read-two and write-one, for identifier bits 0 up to 63. A request is held with stable op and data until `eng_ack`.
- R3: On a read-two acknowledge, `eng_rbits[0]` is the first slot (the identifier bit) and `eng_rbits[1]` is the second slot (its complement). The value 2'b10 selects direction 0. The value 2'b01 selects direction 1. The value 2'b11 ends the pass with status "no devices". The chosen direction becomes identifier bit i and is written in the following write slot.
- R4: On 2'b00 at bit i, the direction is 1 if i equals the stored branch point. If no branch point is stored, or i is above it, the direction is 0 and i is noted as the newest zero branch of this pass. If i is below the branch point, the direction is bit i of the previous identifier.
- R5: After bit 63, the newest zero branch of the pass becomes the stored branch point. If the pass noted none, the search is complete. A request made while the search is complete returns status "complete" one cycle later, with no engine traffic.
- R6: Before responding, the controller computes CRC-8 (reflected polynomial 0x8C, start value 0, least significant bit first) over identifier bits 55:0. If the result differs from bits 63:56, the status is "CRC error". The identifier and the advanced search state are kept either way.
- R7: If the reset acknowledge shows no presence, the pass ends with status "no devices" one cycle later, and no further engine operation is issued.
- R8: `restart` in an idle cycle clears the identifier, the branch point and the completion flag, so that the next pass starts the tree again.
- R9: `rsp_valid` is a single-cycle pulse. `rsp_status` uses 0 = found, 1 = complete, 2 = no devices and 3 = CRC error. A "found" or "CRC error" response comes 58 cycles after the acknowledge of the last write slot. An abort comes 1 cycle after the aborting acknowledge.
- R10: After reset, `busy`, `rsp_valid` and `eng_req` are low. `next_req` while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Clear search state (idle only) |
| alarm_mode | input | 1 | 1 = alarm search, 0 = full search |
| next_req | input | 1 | Start one search pass |
| busy | output | 1 | Pass in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_status | output | 2 | Response status code |
| rsp_addr | output | 64 | Identifier of the last pass |
| eng_req | output | 1 | Engine request, held until acknowledged |
| eng_op | output | 2 | Engine operation code |
| eng_byte | output | 8 | Command byte for the send operation |
| eng_wbit | output | 1 | Bit for the write-one operation |
| eng_ack | input | 1 | Engine completion strobe |
| eng_presence | input | 1 | Presence seen during bus reset |
| eng_rbits | input | 2 | Two slots read (bit 0 first slot) |

## Verification
There are three response deadlines:
- A "complete" response is due one cycle after the request.
- An abort (no presence, or a 2'b11 read) is due one cycle after the deciding acknowledge.
- A "found" or "CRC error" response is due 58 cycles after the acknowledge of the final write slot, once the serial CRC has run.

The bench's bus model records the due cycle whenever it issues the acknowledge that settles a pass. The response monitor compares the actual cycle of `rsp_valid` against it, together with the expected status and identifier held in the scoreboard.

// File: rtl/rom_search_pkg.sv
package rom_search_pkg;

  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_SEND  = 2'd1,
    OP_READ2 = 2'd2,
    OP_WRITE = 2'd3
  } eng_op_e;

  typedef enum logic [1:0] {
    ST_FOUND    = 2'd0,
    ST_COMPLETE = 2'd1,
    ST_NODEV    = 2'd2,
    ST_CRCERR   = 2'd3
  } srch_status_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RESET,
    S_CMD,
    S_READ,
    S_WRITE,
    S_CRC,
    S_CHECK
  } seq_state_e;

endpackage

// File: rtl/rom_search_branch.sv
// Direction choice for one identifier bit from the two-slot read.
module rom_search_branch #(
  parameter int IDX_W = 6
) (
  input  logic [1:0]       rbits,     // [0] true slot, [1] complement slot
  input  logic [IDX_W-1:0] idx,
  input  logic             bp_vld,
  input  logic [IDX_W-1:0] bp_idx,
  input  logic             prev_bit,
  output logic             dir,
  output logic             abort,
  output logic             new_zero
);

  always_comb begin
    dir      = 1'b0;
    abort    = 1'b0;
    new_zero = 1'b0;
    case (rbits)
      2'b10: dir = 1'b0;
      2'b01: dir = 1'b1;
      2'b11: abort = 1'b1;
      default: begin
        if (bp_vld && (idx == bp_idx)) begin
          dir = 1'b1;
        end else if (!bp_vld || (idx > bp_idx)) begin
          dir      = 1'b0;
          new_zero = 1'b1;
        end else begin
          dir = prev_bit;
        end
      end
    endcase
  end

endmodule

// File: rtl/rom_search_crc.sv
// Serial reflected CRC, one data bit per enabled cycle.
module rom_search_crc #(
  parameter int               W    = 8,
  parameter logic [W-1:0]     POLY = 8'h8C
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] crc
);

  logic [W-1:0] crc_q, crc_d;
  logic         mix;

  always_comb begin
    mix   = crc_q[0] ^ din;
    crc_d = crc_q;
    if (clr) begin
      crc_d = '0;
    end else if (en) begin
      crc_d = (crc_q >> 1) ^ (mix ? POLY : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else        crc_q <= crc_d;
  end

  assign crc = crc_q;

endmodule

// File: rtl/rom_search_ctrl.sv
module rom_search_ctrl
  import rom_search_pkg::*;
#(
  parameter int                ADDR_W     = 64,
  parameter int                CMD_W      = 8,
  parameter logic [CMD_W-1:0]  NORMAL_CMD = 8'hF0,
  parameter logic [CMD_W-1:0]  ALARM_CMD  = 8'hEC,
  parameter int                CRC_W      = 8,
  parameter logic [CRC_W-1:0]  CRC_POLY   = 8'h8C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              alarm_mode,
  input  logic              next_req,
  output logic              busy,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              eng_req,
  output logic [1:0]        eng_op,
  output logic [CMD_W-1:0]  eng_byte,
  output logic              eng_wbit,
  input  logic              eng_ack,
  input  logic              eng_presence,
  input  logic [1:0]        eng_rbits
);

  localparam int              IDX_W    = $clog2(ADDR_W);
  localparam int              CRC_SPAN = ADDR_W - CRC_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ADDR_W - 1);
  localparam logic [IDX_W-1:0] CRC_LAST = IDX_W'(CRC_SPAN - 1);

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [IDX_W-1:0]  bp_q, bp_d;
  logic              bp_vld_q, bp_vld_d;
  logic [IDX_W-1:0]  nz_q, nz_d;
  logic              nz_vld_q, nz_vld_d;
  logic              cmpl_q, cmpl_d;
  logic              dir_q, dir_d;
  logic              alarm_q, alarm_d;
  logic [IDX_W-1:0]  cnt_q, cnt_d;
  logic              rv_q, rv_d;
  srch_status_e      st_q, st_d;

  logic              br_dir, br_abort, br_new_zero;
  logic              crc_clr, crc_en;
  logic [CRC_W-1:0]  crc_val;

  rom_search_branch #(.IDX_W(IDX_W)) u_branch (
    .rbits    (eng_rbits),
    .idx      (idx_q),
    .bp_vld   (bp_vld_q),
    .bp_idx   (bp_q),
    .prev_bit (addr_q[idx_q]),
    .dir      (br_dir),
    .abort    (br_abort),
    .new_zero (br_new_zero)
  );

  rom_search_crc #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (crc_clr),
    .en    (crc_en),
    .din   (addr_q[cnt_q]),
    .crc   (crc_val)
  );

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    addr_d   = addr_q;
    idx_d    = idx_q;
    bp_d     = bp_q;
    bp_vld_d = bp_vld_q;
    nz_d     = nz_q;
    nz_vld_d = nz_vld_q;
    cmpl_d   = cmpl_q;
    dir_d    = dir_q;
    alarm_d  = alarm_q;
    cnt_d    = cnt_q;
    rv_d     = 1'b0;
    st_d     = st_q;
    crc_clr  = 1'b0;
    crc_en   = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (restart) begin
          addr_d   = '0;
          bp_d     = '0;
          bp_vld_d = 1'b0;
          cmpl_d   = 1'b0;
        end else if (next_req) begin
          if (cmpl_q) begin
            rv_d = 1'b1;
            st_d = ST_COMPLETE;
          end else begin
            alarm_d  = alarm_mode;
            nz_d     = '0;
            nz_vld_d = 1'b0;
            state_d  = S_RESET;
          end
        end
      end
      S_RESET: begin
        if (eng_ack) begin
          if (eng_presence) begin
            state_d = S_CMD;
          end else begin
            rv_d    = 1'b1;
            st_d    = ST_NODEV;
            state_d = S_IDLE;
          end
        end
      end
      S_CMD: begin
        if (eng_ack) begin
          idx_d   = '0;
          state_d = S_READ;
        end
      end
      S_READ: begin
        if (eng_ack) begin
          if (br_abort) begin
            rv_d    = 1'b1;
            st_d    = ST_NODEV;
            state_d = S_IDLE;
          end else begin
            addr_d[idx_q] = br_dir;
            dir_d         = br_dir;
            if (br_new_zero) begin
              nz_d     = idx_q;
              nz_vld_d = 1'b1;
            end
            state_d = S_WRITE;
          end
        end
      end
      S_WRITE: begin
        if (eng_ack) begin
          if (idx_q == LAST_IDX) begin
            bp_d     = nz_q;
            bp_vld_d = nz_vld_q;
            cmpl_d   = !nz_vld_q;
            crc_clr  = 1'b1;
            cnt_d    = '0;
            state_d  = S_CRC;
          end else begin
            idx_d   = idx_q + 1'b1;
            state_d = S_READ;
          end
        end
      end
      S_CRC: begin
        crc_en = 1'b1;
        cnt_d  = cnt_q + 1'b1;
        if (cnt_q == CRC_LAST) state_d = S_CHECK;
      end
      S_CHECK: begin
        rv_d    = 1'b1;
        st_d    = (crc_val == addr_q[ADDR_W-1 -: CRC_W]) ? ST_FOUND : ST_CRCERR;
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      addr_q   <= '0;
      idx_q    <= '0;
      bp_q     <= '0;
      bp_vld_q <= 1'b0;
      nz_q     <= '0;
      nz_vld_q <= 1'b0;
      cmpl_q   <= 1'b0;
      dir_q    <= 1'b0;
      alarm_q  <= 1'b0;
      cnt_q    <= '0;
      rv_q     <= 1'b0;
      st_q     <= ST_FOUND;
    end else begin
      state_q  <= state_d;
      addr_q   <= addr_d;
      idx_q    <= idx_d;
      bp_q     <= bp_d;
      bp_vld_q <= bp_vld_d;
      nz_q     <= nz_d;
      nz_vld_q <= nz_vld_d;
      cmpl_q   <= cmpl_d;
      dir_q    <= dir_d;
      alarm_q  <= alarm_d;
      cnt_q    <= cnt_d;
      rv_q     <= rv_d;
      st_q     <= st_d;
    end
  end

  // Outputs
  always_comb begin
    eng_req = 1'b0;
    eng_op  = OP_RESET;
    case (state_q)
      S_RESET: begin eng_req = 1'b1; eng_op = OP_RESET; end
      S_CMD:   begin eng_req = 1'b1; eng_op = OP_SEND;  end
      S_READ:  begin eng_req = 1'b1; eng_op = OP_READ2; end
      S_WRITE: begin eng_req = 1'b1; eng_op = OP_WRITE; end
      default: ;
    endcase
  end

  assign eng_byte   = alarm_q ? ALARM_CMD : NORMAL_CMD;
  assign eng_wbit   = dir_q;
  assign busy       = (state_q != S_IDLE);
  assign rsp_valid  = rv_q;
  assign rsp_status = st_q;
  assign rsp_addr   = addr_q;

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && !eng_ack) |=> (eng_req && $stable(eng_op) && $stable(eng_byte) && $stable(eng_wbit)));

  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R5
  cmpl_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmpl_q && next_req && !restart) |=> (rsp_valid && rsp_status == 2'(ST_COMPLETE) && !busy));

  // R7
  no_presence_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_RESET && eng_ack && !eng_presence) |=> (!busy && rsp_valid && rsp_status == 2'(ST_NODEV)));

  // R3
  read_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_READ && eng_ack && eng_rbits == 2'b11) |=> (!busy && rsp_valid && rsp_status == 2'(ST_NODEV)));

endmodule

// File: tb/test_rom_search_ctrl.sv
module test_rom_search_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        restart, alarm_mode, next_req;
  logic        busy, rsp_valid;
  logic [1:0]  rsp_status;
  logic [63:0] rsp_addr;
  logic        eng_req;
  logic [1:0]  eng_op;
  logic [7:0]  eng_byte;
  logic        eng_wbit;
  logic        eng_ack, eng_presence;
  logic [1:0]  eng_rbits;

  rom_search_ctrl i_rom_search_ctrl (
    .clk(clk), .rst_n(rst_n), .restart(restart), .alarm_mode(alarm_mode),
    .next_req(next_req), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_status(rsp_status), .rsp_addr(rsp_addr), .eng_req(eng_req),
    .eng_op(eng_op), .eng_byte(eng_byte), .eng_wbit(eng_wbit),
    .eng_ack(eng_ack), .eng_presence(eng_presence), .eng_rbits(eng_rbits)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0, resp_cnt = 0, due = -1;
  bit done = 0;

  // bus model state
  logic [63:0] rom [4];
  bit          alm [4];
  int          ndev = 0;
  bit          active [4];
  int          bitpos = 0;
  logic [7:0]  last_cmd = 8'h00;
  int          last_op = -1;
  int          exp_op = 0;
  int          seq_err = 0;

  typedef struct {
    logic [1:0]  st;
    logic [63:0] addr;
    bit          chk_addr;
    string       req;
  } exp_t;
  exp_t sb[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [7:0] crc8(input logic [55:0] d);
    logic [7:0] c;
    logic       m;
    c = 8'h00;
    for (int i = 0; i < 56; i++) begin
      m = c[0] ^ d[i];
      c = c >> 1;
      if (m) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  function automatic logic [63:0] mkrom(input logic [55:0] ser);
    return {crc8(ser), ser};
  endfunction

  // Slot-engine and device model
  initial begin
    logic b0, b1, pres;
    eng_ack = 0; eng_presence = 0; eng_rbits = 2'b11;
    forever begin
      @(negedge clk);
      if (rst_n && eng_req) begin
        repeat (2) @(negedge clk);
        last_op = int'(eng_op);
        case (eng_op)
          2'd0: begin
            pres = (ndev > 0);
            eng_presence = pres;
            if (!pres) due = cyc + 1;
            for (int i = 0; i < 4; i++) active[i] = (i < ndev);
            bitpos = 0;
            exp_op = 1;
          end
          2'd1: begin
            if (exp_op != 1) seq_err++;
            last_cmd = eng_byte;
            for (int i = 0; i < 4; i++)
              if (eng_byte == 8'hEC) active[i] = active[i] && alm[i];
              else if (eng_byte != 8'hF0) active[i] = 0;
            exp_op = 2;
          end
          2'd2: begin
            if (exp_op != 2) seq_err++;
            b0 = 1; b1 = 1;
            for (int i = 0; i < 4; i++)
              if (active[i]) begin
                b0 = b0 & rom[i][bitpos];
                b1 = b1 & ~rom[i][bitpos];
              end
            eng_rbits = {b1, b0};
            if (b0 && b1) due = cyc + 1;
            exp_op = 3;
          end
          default: begin
            if (exp_op != 3) seq_err++;
            for (int i = 0; i < 4; i++)
              if (active[i] && rom[i][bitpos] != eng_wbit) active[i] = 0;
            if (bitpos == 63) due = cyc + 58;
            bitpos++;
            exp_op = 2;
          end
        endcase
        eng_ack = 1;
        @(negedge clk);
        eng_ack = 0;
      end
    end
  end

  // Monitor: pop expected item on each response
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        check(0, "R10", "unexpected response", 64'(rsp_status), 64'hFFFF);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(rsp_status == e.st, e.req, "status", 64'(rsp_status), 64'(e.st));
        if (e.chk_addr)
          check(rsp_addr == e.addr, e.req, "address", rsp_addr, e.addr);
        check(cyc == due, "R9", "response cycle", 64'(cyc), 64'(due));
      end
      resp_cnt++;
    end
  end

  task automatic do_next(input bit alarm, input logic [1:0] st, input logic [63:0] addr,
                         input bit chk, input string req, input int hold);
    exp_t e;
    int   n;
    e.st = st; e.addr = addr; e.chk_addr = chk; e.req = req;
    sb.push_back(e);
    n = resp_cnt;
    @(negedge clk);
    alarm_mode = alarm;
    next_req = 1;
    if (st == 2'd1) due = cyc + 1;
    repeat (hold) @(negedge clk);
    next_req = 0;
    while (resp_cnt == n) @(negedge clk);
    repeat (3) @(negedge clk);
    check(sb.size() == 0, req, "pending items", 64'(sb.size()), 64'd0);
    if (st == 2'd0 || st == 2'd3)
      check(bitpos == 64, "R2", "write slots in pass", 64'(bitpos), 64'd64);
  endtask

  task automatic do_restart();
    @(negedge clk); restart = 1;
    @(negedge clk); restart = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "R9", "watchdog expired", 64'(cyc), 64'd0);
    finish_run();
  end

  initial begin
    logic [63:0] dA, dB, dC, dBad;
    dA = mkrom(56'h11223344556628);
    dB = mkrom(56'h0A0B0C0D0E0F05);
    dC = mkrom(56'h77665544332213);
    dBad = mkrom(56'h01020304050622) ^ 64'hFF00_0000_0000_0000;
    rom[0] = dA; rom[1] = dB; rom[2] = dC; rom[3] = dBad;
    alm[0] = 0; alm[1] = 1; alm[2] = 1; alm[3] = 0;
    ndev = 3;
    rst_n = 0; restart = 0; alarm_mode = 0; next_req = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(busy == 0, "R10", "busy after reset", 64'(busy), 0);
    check(rsp_valid == 0, "R10", "rsp_valid after reset", 64'(rsp_valid), 0);
    check(eng_req == 0, "R10", "eng_req after reset", 64'(eng_req), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // Full search of three devices; R3/R4 ordering through branch points
    do_next(0, 2'd0, dA, 1, "R3", 1);
    check(last_cmd == 8'hF0, "R1", "normal command byte", 64'(last_cmd), 64'hF0);
    check(seq_err == 0, "R2", "operation order", 64'(seq_err), 0);
    do_next(0, 2'd0, dB, 1, "R4", 3);   // next_req held while busy (R10)
    do_next(0, 2'd0, dC, 1, "R4", 1);
    do_next(0, 2'd1, 64'h0, 0, "R5", 1);
    do_next(0, 2'd1, 64'h0, 0, "R5", 1);

    // R8 restart returns to the first leaf
    do_restart();
    do_next(0, 2'd0, dA, 1, "R8", 1);

    // R1 alarm search
    do_restart();
    do_next(1, 2'd0, dB, 1, "R1", 1);
    check(last_cmd == 8'hEC, "R1", "alarm command byte", 64'(last_cmd), 64'hEC);
    do_next(1, 2'd0, dC, 1, "R1", 1);
    do_next(1, 2'd1, 64'h0, 0, "R5", 1);

    // R3 abort on 1,1 read (alarm search, no device flagged)
    alm[1] = 0; alm[2] = 0;
    do_restart();
    do_next(1, 2'd2, 64'h0, 0, "R3", 1);
    do_next(0, 2'd0, dA, 1, "R1", 1);

    // R7 no presence
    ndev = 0;
    do_restart();
    do_next(0, 2'd2, 64'h0, 0, "R7", 1);
    check(last_op == 0, "R7", "last engine op", 64'(last_op), 0);

    // R6 CRC mismatch keeps advanced state
    rom[0] = dBad; ndev = 1;
    do_restart();
    do_next(0, 2'd3, dBad, 1, "R6", 1);
    do_next(0, 2'd1, 64'h0, 0, "R6", 1);

    check(seq_err == 0, "R2", "operation order", 64'(seq_err), 0);
    finish_run();
  end

endmodule